// File: doc/BRIEF.md
# Mode Register Update Scheduler

This block sits inside a DDR3 memory controller and decides when mode register set commands go out to the DRAM. It keeps a stored copy of four mode registers: the main mode register and the three extended ones. Software updates these copies through a simple write port. A write queues an update command for that register only when the register's enable bit is set. A power-on initialization request queues updates for all four registers, whatever the enable bits say.

Each register has its own pending flag. Pending updates are handed to a downstream command port one at a time through a valid/ready handshake. Lower register selects go first. No command is offered while a data transfer is in flight. A command waits until the transfer indication drops, so it never lands inside a burst. A command carries a 2-bit register select and the value stored for that register at the moment it is accepted. A register rewritten while its update waits is therefore sent once, with the newest value.

Top module: `mrs_update_sched`

## Requirements
- R1: While reset is asserted `cmd_valid` is 0. After reset, no update is pending and all four stored values are 0.
- R2: A cycle with `init_req` = 1 queues updates for all four registers, whatever `mask_en` holds. They are then issued with select 0, 1, 2, 3 in that order.
- R3: A write (`wr_en` = 1) whose select bit in `mask_en` is 1 stores `wr_data` and queues an update. The command is offered from the cycle after the write.
- R4: A write whose select bit in `mask_en` is 0 stores `wr_data` but queues nothing. The stored value only leaves the block with a later update of that register.
- R5: While `xfer_busy` = 1, `cmd_valid` is 0 and `cmd_ready` has no effect. A queued update is offered in the first cycle that `xfer_busy` is 0.
- R6: When several updates are queued, the lowest select is offered first.
- R7: `cmd_sel` encodes the register as 0 = main, 1 = extended 1, 2 = extended 2, 3 = extended 3. `cmd_value` is the value currently stored for that register.
- R8: Writing a register again while its update is queued leaves one queued update. That update carries the newest value.
- R9: A queued update is removed in the cycle `cmd_valid` and `cmd_ready` are both 1. Until then, the offered command holds steady as long as there are no new writes.
- R10: A write that queues a register in the same cycle as that register's command is accepted keeps the register queued. The new value is then sent as a further command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released after two clock edges |
| init_req | input | 1 | Single-cycle request from the initialization sequence to refresh all registers |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written (0 main, 1..3 extended) |
| wr_data | input | DATA_W | Value written |
| mask_en | input | 4 | Per-register enable; bit n lets writes to register n queue an update |
| xfer_busy | input | 1 | A data transfer is in progress |
| cmd_ready | input | 1 | Downstream accepts the offered command |
| cmd_valid | output | 1 | A mode register set command is offered |
| cmd_sel | output | 2 | Register the command targets |
| cmd_value | output | DATA_W | Value to load into that register |

## Verification
A write or an initialization request changes the command outputs in the cycle after the edge that captures it. `xfer_busy` gates `cmd_valid` in the same cycle, with no register in the path. An acceptance removes the update at that edge, so the next queued command appears in the following cycle. The bench drives every input on the falling edge and samples the outputs one time unit later, inside the same cycle. Each table row therefore states the outputs expected for the state left by the previous rows and for that row's busy level. After `rst_n` is released, the bench waits out the two-edge release delay before it applies any stimulus.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int unsigned MRS_NUM_REGS = 4;
  localparam int unsigned MRS_SEL_W    = $clog2(MRS_NUM_REGS);

  typedef enum logic [MRS_SEL_W-1:0] {
    MRS_SEL_MAIN = 2'd0,
    MRS_SEL_EXT1 = 2'd1,
    MRS_SEL_EXT2 = 2'd2,
    MRS_SEL_EXT3 = 2'd3
  } mrs_sel_e;
endpackage

// File: rtl/mrs_reset_sync.sv
module mrs_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mrs_shadow_bank.sv
module mrs_shadow_bank
  import mrs_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = MRS_NUM_REGS,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  val_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              load_en;
    logic [DATA_W-1:0] val_d;

    always_comb begin
      load_en = wr_en && (wr_sel == SEL_W'(g));
      val_d   = load_en ? wr_data : val_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_q[g] <= '0;
      else if (load_en) val_q[g] <= val_d;
    end
  end
endmodule

// File: rtl/mrs_pending_tracker.sv
module mrs_pending_tracker
  import mrs_pkg::*;
#(
  parameter int unsigned NUM_REGS = MRS_NUM_REGS,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_req,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [NUM_REGS-1:0] mask_en,
  input  logic                accept,
  input  logic [SEL_W-1:0]    accept_sel,
  output logic [NUM_REGS-1:0] pend_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
    logic set_req;
    logic clr_req;
    logic flag_en;
    logic flag_d;

    always_comb begin
      set_req = init_req || (wr_en && (wr_sel == SEL_W'(g)) && mask_en[g]);
      clr_req = accept && (accept_sel == SEL_W'(g));
      flag_en = set_req || clr_req;
      flag_d  = set_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q[g] <= 1'b0;
      else if (flag_en) pend_q[g] <= flag_d;
    end
  end
endmodule

// File: rtl/mrs_issue_arbiter.sv
module mrs_issue_arbiter
  import mrs_pkg::*;
#(
  parameter int unsigned NUM_REGS = MRS_NUM_REGS,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] pend,
  input  logic                xfer_busy,
  input  logic                cmd_ready,
  output logic                cmd_valid,
  output logic [SEL_W-1:0]    cmd_sel,
  output logic                accept
);
  always_comb begin
    cmd_sel = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (pend[i]) cmd_sel = SEL_W'(i);
    end
    cmd_valid = (|pend) && !xfer_busy;
    accept    = cmd_valid && cmd_ready;
  end
endmodule

// File: rtl/mrs_update_sched.sv
module mrs_update_sched
  import mrs_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        mask_en,
  input  logic              xfer_busy,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [1:0]        cmd_sel,
  output logic [DATA_W-1:0] cmd_value
);
  localparam int unsigned NUM_REGS = MRS_NUM_REGS;
  localparam int unsigned SEL_W    = MRS_SEL_W;

  logic                            rst_sync_n;
  logic [NUM_REGS-1:0][DATA_W-1:0] val_q;
  logic [NUM_REGS-1:0]             pend_q;
  logic                            accept;
  logic [SEL_W-1:0]                sel_w;

  mrs_reset_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mrs_shadow_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .val_q   (val_q)
  );

  mrs_pending_tracker #(.NUM_REGS(NUM_REGS)) u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .init_req   (init_req),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .mask_en    (mask_en),
    .accept     (accept),
    .accept_sel (sel_w),
    .pend_q     (pend_q)
  );

  mrs_issue_arbiter #(.NUM_REGS(NUM_REGS)) u_arb (
    .pend      (pend_q),
    .xfer_busy (xfer_busy),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_sel   (sel_w),
    .accept    (accept)
  );

  assign cmd_sel   = sel_w;
  assign cmd_value = val_q[sel_w];
endmodule

// File: rtl/mrs_update_sched_chk.sv
module mrs_update_sched_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              init_req,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [3:0]        mask_en,
  input logic              xfer_busy,
  input logic              cmd_ready,
  input logic              cmd_valid,
  input logic [1:0]        cmd_sel,
  input logic [DATA_W-1:0] cmd_value,
  input logic [3:0]        pend
);
  // R5: nothing is offered during a transfer
  a_r5_quiet_in_xfer: assert property (@(posedge clk) disable iff (!rst_ok)
    xfer_busy |-> !cmd_valid);

  // R6: no lower select is left waiting behind the offered one
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_ok)
    cmd_valid |-> ((pend & ((4'b1 << cmd_sel) - 4'b1)) == 4'b0));

  // R3: an enabled write leaves its register queued
  a_r3_enabled_write_queues: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && mask_en[wr_sel]) |=> pend[$past(wr_sel)]);

  // R4: a disabled write queues nothing
  a_r4_disabled_write_silent: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && !mask_en[wr_sel] && !init_req && !pend[wr_sel]) |=> !pend[$past(wr_sel)]);

  // R9: acceptance removes the update
  a_r9_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_ready && !init_req && !(wr_en && wr_sel == cmd_sel && mask_en[wr_sel]))
      |=> !pend[$past(cmd_sel)]);

  // R9: an unaccepted command holds steady with no new writes
  a_r9_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && !cmd_ready && !wr_en && !init_req)
      |=> (xfer_busy || (cmd_valid && $stable(cmd_sel) && $stable(cmd_value))));
endmodule

bind mrs_update_sched mrs_update_sched_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .init_req  (init_req),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .mask_en   (mask_en),
  .xfer_busy (xfer_busy),
  .cmd_ready (cmd_ready),
  .cmd_valid (cmd_valid),
  .cmd_sel   (cmd_sel),
  .cmd_value (cmd_value),
  .pend      (pend_q)
);

// File: tb/mrs_update_sched_tb.sv
module mrs_update_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int NVEC       = 30;

  typedef struct packed {
    logic        init;
    logic        wr;
    logic [1:0]  sel;
    logic [15:0] data;
    logic [3:0]  mask;
    logic        busy;
    logic        rdy;
    logic        ev;
    logic [1:0]  es;
    logic [15:0] ed;
    logic [3:0]  rq;
  } vec_t;

  // init wr sel data mask busy rdy | exp_valid exp_sel exp_value | req
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd1}, // R1 idle
    '{1'b0,1'b1,2'd1,16'h1111,4'hF,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd3}, // R3 write ext1
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b0, 1'b1,2'd1,16'h1111, 4'd3}, // R3 offered
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b1, 1'b1,2'd1,16'h1111, 4'd9}, // R9 held, accept
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd9}, // R9 cleared
    '{1'b0,1'b1,2'd2,16'h2222,4'hB,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd4}, // R4 disabled write
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd4}, // R4 nothing queued
    '{1'b0,1'b1,2'd3,16'h3333,4'hF,1'b1,1'b0, 1'b0,2'd0,16'h0000, 4'd5}, // R5 write in xfer
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b1,1'b1, 1'b0,2'd0,16'h0000, 4'd5}, // R5 held back
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b0, 1'b1,2'd3,16'h3333, 4'd5}, // R5 released
    '{1'b0,1'b1,2'd0,16'hAAAA,4'hF,1'b0,1'b0, 1'b1,2'd3,16'h3333, 4'd7}, // R7 ext3 = 3
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b0, 1'b1,2'd0,16'hAAAA, 4'd6}, // R6 main first
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b1, 1'b1,2'd0,16'hAAAA, 4'd6}, // R6 accept main
    '{1'b0,1'b1,2'd3,16'h4444,4'hF,1'b0,1'b0, 1'b1,2'd3,16'h3333, 4'd8}, // R8 rewrite ext3
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b1, 1'b1,2'd3,16'h4444, 4'd8}, // R8 newest value
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd8}, // R8 sent once
    '{1'b0,1'b1,2'd1,16'h5555,4'hF,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd10},// R10 write
    '{1'b0,1'b1,2'd1,16'h6666,4'hF,1'b0,1'b1, 1'b1,2'd1,16'h5555, 4'd10},// R10 accept+rewrite
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b1, 1'b1,2'd1,16'h6666, 4'd10},// R10 still queued
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd10},
    '{1'b1,1'b0,2'd0,16'h0000,4'h0,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd2}, // R2 init, mask 0
    '{1'b0,1'b0,2'd0,16'h0000,4'h0,1'b0,1'b1, 1'b1,2'd0,16'hAAAA, 4'd2},
    '{1'b0,1'b0,2'd0,16'h0000,4'h0,1'b0,1'b1, 1'b1,2'd1,16'h6666, 4'd2},
    '{1'b0,1'b0,2'd0,16'h0000,4'h0,1'b0,1'b1, 1'b1,2'd2,16'h2222, 4'd4}, // R4 stored value out
    '{1'b0,1'b0,2'd0,16'h0000,4'h0,1'b0,1'b1, 1'b1,2'd3,16'h4444, 4'd2},
    '{1'b0,1'b0,2'd0,16'h0000,4'h0,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd2},
    '{1'b0,1'b1,2'd2,16'h7777,4'hF,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd5},
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b1,1'b1, 1'b0,2'd0,16'h0000, 4'd5}, // R5 ready ignored
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b1, 1'b1,2'd2,16'h7777, 4'd5},
    '{1'b0,1'b0,2'd0,16'h0000,4'hF,1'b0,1'b0, 1'b0,2'd0,16'h0000, 4'd5}
  };

  logic              clk;
  logic              rst_n;
  logic              init_req;
  logic              wr_en;
  logic [1:0]        wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic [3:0]        mask_en;
  logic              xfer_busy;
  logic              cmd_ready;
  logic              cmd_valid;
  logic [1:0]        cmd_sel;
  logic [DATA_W-1:0] cmd_value;

  int n_checks;
  int n_fail;
  int cycles;

  mrs_update_sched #(.DATA_W(DATA_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_req  (init_req),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .mask_en   (mask_en),
    .xfer_busy (xfer_busy),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_sel   (cmd_sel),
    .cmd_value (cmd_value)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic drive(input logic i, input logic w, input logic [1:0] s,
                       input logic [15:0] d, input logic [3:0] m,
                       input logic b, input logic r);
    init_req = i; wr_en = w; wr_sel = s; wr_data = d;
    mask_en = m; xfer_busy = b; cmd_ready = r;
  endtask

  task automatic expect_cmd(input string tag, input logic ev,
                            input logic [1:0] es, input logic [15:0] ed);
    n_checks++;
    if (cmd_valid !== ev || (ev && (cmd_sel !== es || cmd_value !== ed))) begin
      n_fail++;
      $display("FAIL %s: valid=%0b sel=%0d value=%h, expected valid=%0b sel=%0d value=%h",
               tag, cmd_valid, cmd_sel, cmd_value, ev, es, ed);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d, expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; cycles = 0;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 2'd0, 16'h0, 4'hF, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    #1 expect_cmd("R1 during reset", 1'b0, 2'd0, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      drive(VEC[k].init, VEC[k].wr, VEC[k].sel, VEC[k].data,
            VEC[k].mask, VEC[k].busy, VEC[k].rdy);
      #1 expect_cmd($sformatf("vector %0d R%0d", k, VEC[k].rq),
                    VEC[k].ev, VEC[k].es, VEC[k].ed);
    end

    // R1: reset mid-run drops the command and clears the stored values
    @(negedge clk); drive(1'b0, 1'b1, 2'd0, 16'hBEEF, 4'hF, 1'b0, 1'b0);
    @(negedge clk); drive(1'b0, 1'b0, 2'd0, 16'h0, 4'hF, 1'b0, 1'b0);
    #1 expect_cmd("R3 before reset", 1'b1, 2'd0, 16'hBEEF);
    rst_n = 1'b0;
    #1 expect_cmd("R1 async assert", 1'b0, 2'd0, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 expect_cmd("R1 nothing queued", 1'b0, 2'd0, 16'h0);
    @(negedge clk); drive(1'b1, 1'b0, 2'd0, 16'h0, 4'h0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); drive(1'b0, 1'b0, 2'd0, 16'h0, 4'h0, 1'b0, 1'b1);
      #1 expect_cmd($sformatf("R1 cleared value, sel %0d", k), 1'b1, 2'(k), 16'h0000);
    end
    @(negedge clk); drive(1'b0, 1'b0, 2'd0, 16'h0, 4'h0, 1'b0, 1'b0);
    #1 expect_cmd("R2 init drained", 1'b0, 2'd0, 16'h0);

    finish_run();
  end
endmodule